// File: doc/BRIEF.md
# Load-Dependent Valley Count Regulator

In a quasi-resonant flyback controller the switch is turned on at a valley of the drain ringing after the transformer has demagnetised. This block decides how many valleys to let pass before that turn-on. Heavier load means fewer skipped valleys and a higher switching frequency. Lighter load means more skipped valleys and a lower frequency. The block reads three comparator flags, which show whether the regulation voltage is above a low, a middle and a high threshold. From them it keeps a saturating count in the range 1 to 7, and a zero-crossing counter outside the block compares against that count.

The count moves slowly. A prescaler on the system clock cuts time into evaluation windows, and the default window is 48 ms at 125 MHz. A sticky register keeps the highest threshold level seen during the current window. At the end of each window that peak raises the count by one, holds it or lowers it by one. A large load step takes a fast path instead: once the top threshold has been crossed, the next switching-period strobe forces the count to 1. Leaving burst mode also forces the count to 1 at once. A separate flag shows when the count sits at 7, which is one of the conditions for entering burst mode.

Top module: `valley_count_reg`

## Requirements
- R1: While reset is asserted, and afterwards until the first update, the count output is 1 and the at-maximum flag is 0. Reset is asserted asynchronously and released two clock edges after the reset input rises.
- R2: The count never leaves 1..7. A step up at 7 or a step down at 1 leaves the count unchanged.
- R3: If, during a whole window, the regulation level was never above the low threshold, the count rises by one at the window end.
- R4: If the highest level seen in a window was above the low threshold but never above the middle one, the count is unchanged at the window end.
- R5: If the highest level seen in a window was above the middle threshold but never above the high one, the count falls by one at the window end.
- R6: A cycle in which the level is above the high threshold arms a fast force. The first period strobe in a later cycle then sets the count to 1 at the edge that samples that strobe, without waiting for a window end.
- R7: If the level was above the high threshold at any time in a window, the count is 1 after the window end.
- R8: A burst-exit pulse sets the count to 1 at the clock edge that samples it. This has priority over a window step.
- R9: Apart from the force paths of R6 and R8, the count changes only at window ends, by at most one step each time.
- R10: The at-maximum output is 1 exactly when the count is 7.
- R11: A level excursion of even one cycle anywhere in a window counts toward that window's peak. The peak is cleared at each window end, so the following window is judged only on its own samples. Window ends come every TICK_CYCLES clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| above_low_i | input | 1 | Regulation level above the low threshold |
| above_mid_i | input | 1 | Regulation level above the middle threshold |
| above_high_i | input | 1 | Regulation level above the high threshold |
| period_strobe_i | input | 1 | One-cycle pulse at each switching period start |
| burst_exit_i | input | 1 | One-cycle pulse when burst mode is left |
| valley_count_o | output | 3 | Number of valleys to skip, 1..7 |
| count_at_max_o | output | 1 | Count equals 7 |

## Verification
The first directed patterns hold the level constant for a whole window, in turn below, between and above the thresholds. They tell apart the rise, hold and fall rules, and they push the count into both saturation limits. One-cycle excursions placed in the middle of a window show that the peak is sticky and that it is cleared for the next window. A top crossing followed by a strobe separates the fast force from the window path. A top level with no strobe at all isolates the window-end force to 1, and a burst-exit pulse shows the immediate override. A long seeded random run follows, with changing per-window levels, glitches, strobes and rare burst exits, compared on every cycle against a model written from the rules above.

// File: rtl/vcr_pkg.sv
package vcr_pkg;
  typedef enum logic [1:0] {
    LVL_NONE = 2'd0,
    LVL_LOW  = 2'd1,
    LVL_MID  = 2'd2,
    LVL_TOP  = 2'd3
  } vcr_level_e;

  localparam int unsigned CNT_W     = 3;
  localparam int unsigned COUNT_MIN = 1;
  localparam int unsigned COUNT_MAX = 7;
endpackage

// File: rtl/vcr_window_timer.sv
module vcr_window_timer #(
  parameter int unsigned TICK_CYCLES = 6_000_000
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);
  localparam int unsigned TW = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
  localparam logic [TW-1:0] LAST = TW'(TICK_CYCLES - 1);

  logic [TW-1:0] cnt_q, cnt_d;

  always_comb begin
    tick_o = (cnt_q == LAST);
    cnt_d  = tick_o ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  generate
    if (TICK_CYCLES > 1) begin : g_tick_gap
      // R11
      tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);
    end
  endgenerate
endmodule

// File: rtl/vcr_peak_tracker.sv
module vcr_peak_tracker
  import vcr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       above_low_i,
  input  logic       above_mid_i,
  input  logic       above_high_i,
  input  logic       tick_i,
  input  logic       strobe_i,
  output vcr_level_e win_level_o,
  output logic       force_o
);
  vcr_level_e lvl_now, peak_q, peak_d;
  logic       pend_q, pend_d;

  always_comb begin
    if (above_high_i)     lvl_now = LVL_TOP;
    else if (above_mid_i) lvl_now = LVL_MID;
    else if (above_low_i) lvl_now = LVL_LOW;
    else                  lvl_now = LVL_NONE;
    win_level_o = (lvl_now > peak_q) ? lvl_now : peak_q;
    peak_d      = tick_i ? LVL_NONE : win_level_o;
    force_o     = strobe_i & pend_q;
    pend_d      = (pend_q & ~strobe_i) | (lvl_now == LVL_TOP);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      peak_q <= LVL_NONE;
      pend_q <= 1'b0;
    end else begin
      peak_q <= peak_d;
      pend_q <= pend_d;
    end
  end

  // R6
  top_arms_chk: assert property (@(posedge clk) disable iff (!rst_n)
    above_high_i |=> pend_q);
  // R11
  peak_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && above_mid_i) |=> (win_level_o >= LVL_MID));
endmodule

// File: rtl/vcr_count_core.sv
module vcr_count_core
  import vcr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  vcr_level_e       win_level_i,
  input  logic             force_i,
  input  logic             burst_exit_i,
  output logic [CNT_W-1:0] count_o
);
  localparam logic [CNT_W-1:0] CMIN = CNT_W'(COUNT_MIN);
  localparam logic [CNT_W-1:0] CMAX = CNT_W'(COUNT_MAX);

  logic [CNT_W-1:0] count_q, count_d;
  logic             count_en;

  always_comb begin
    count_en = burst_exit_i | force_i | tick_i;
    count_d  = count_q;
    if (burst_exit_i || force_i) begin
      count_d = CMIN;
    end else if (tick_i) begin
      unique case (win_level_i)
        LVL_NONE: if (count_q != CMAX) count_d = count_q + 1'b1;
        LVL_LOW:  count_d = count_q;
        LVL_MID:  if (count_q != CMIN) count_d = count_q - 1'b1;
        LVL_TOP:  count_d = CMIN;
        default:  count_d = count_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        count_q <= CMIN;
    else if (count_en) count_q <= count_d;
  end

  assign count_o = count_q;

  // R2
  count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (count_q >= CMIN) && (count_q <= CMAX));
  // R8
  burst_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    burst_exit_i |=> (count_q == CMIN));
  // R9
  hold_between_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && !force_i && !burst_exit_i) |=> $stable(count_q));
  // R3
  step_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && win_level_i == LVL_NONE && !force_i && !burst_exit_i && count_q != CMAX)
      |=> (count_q == $past(count_q) + 1'b1));
endmodule

// File: rtl/valley_count_reg.sv
module valley_count_reg
  import vcr_pkg::*;
#(
  parameter int unsigned TICK_CYCLES = 6_000_000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             above_low_i,
  input  logic             above_mid_i,
  input  logic             above_high_i,
  input  logic             period_strobe_i,
  input  logic             burst_exit_i,
  output logic [CNT_W-1:0] valley_count_o,
  output logic             count_at_max_o
);
  logic       sync0_q, sync1_q;
  logic       tick;
  logic       force_one;
  vcr_level_e win_level;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync0_q <= 1'b0;
      sync1_q <= 1'b0;
    end else begin
      sync0_q <= 1'b1;
      sync1_q <= sync0_q;
    end
  end

  vcr_window_timer #(.TICK_CYCLES(TICK_CYCLES)) u_timer (
    .clk    (clk),
    .rst_n  (sync1_q),
    .tick_o (tick)
  );

  vcr_peak_tracker u_peak (
    .clk          (clk),
    .rst_n        (sync1_q),
    .above_low_i  (above_low_i),
    .above_mid_i  (above_mid_i),
    .above_high_i (above_high_i),
    .tick_i       (tick),
    .strobe_i     (period_strobe_i),
    .win_level_o  (win_level),
    .force_o      (force_one)
  );

  vcr_count_core u_core (
    .clk          (clk),
    .rst_n        (sync1_q),
    .tick_i       (tick),
    .win_level_i  (win_level),
    .force_i      (force_one),
    .burst_exit_i (burst_exit_i),
    .count_o      (valley_count_o)
  );

  assign count_at_max_o = (valley_count_o == CNT_W'(COUNT_MAX));

  // R6
  fast_force_chk: assert property (@(posedge clk) disable iff (!sync1_q)
    force_one |=> (valley_count_o == CNT_W'(COUNT_MIN)));
endmodule

// File: tb/valley_count_reg_tb.sv
`timescale 1ns/1ps
module valley_count_reg_tb;
  localparam int TICK = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lo = 1'b0, mi = 1'b0, hi = 1'b0, strobe = 1'b0, bexit = 1'b0;
  logic [2:0] count;
  logic at_max;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  valley_count_reg #(.TICK_CYCLES(TICK)) u_dut (
    .clk(clk), .rst_n(rst_n), .above_low_i(lo), .above_mid_i(mi),
    .above_high_i(hi), .period_strobe_i(strobe), .burst_exit_i(bexit),
    .valley_count_o(count), .count_at_max_o(at_max)
  );

  // requirement model
  logic m_s0, m_s1, m_pend;
  int m_cnt, m_peak, m_count, m_ticks;
  string m_tag;

  function automatic int level_of(logic l, logic m, logic h);
    return h ? 3 : (m ? 2 : (l ? 1 : 0));
  endfunction

  function automatic int next_count(int c, int pk);
    case (pk)
      0: return (c < 7) ? c + 1 : 7;
      1: return c;
      2: return (c > 1) ? c - 1 : 1;
      default: return 1;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s0 <= 0; m_s1 <= 0;
    end else begin
      m_s0 <= 1; m_s1 <= m_s0;
    end
  end

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n || !m_s1) begin
      m_cnt <= 0; m_peak <= 0; m_pend <= 0; m_count <= 1; m_tag <= "R1";
      if (!rst_n) m_ticks <= 0;
    end else begin
      int lv, pk;
      bit tk;
      lv = level_of(lo, mi, hi);
      pk = (lv > m_peak) ? lv : m_peak;
      tk = (m_cnt == TICK - 1);
      m_cnt  <= tk ? 0 : m_cnt + 1;
      m_peak <= tk ? 0 : pk;
      m_pend <= (m_pend && !strobe) || (lv == 3);
      if (tk) m_ticks <= m_ticks + 1;
      if (bexit) begin
        m_count <= 1; m_tag <= "R8";
      end else if (strobe && m_pend) begin
        m_count <= 1; m_tag <= "R6";
      end else if (tk) begin
        m_count <= next_count(m_count, pk);
        if (next_count(m_count, pk) == m_count && pk != 1) m_tag <= "R2";
        else m_tag <= (pk == 0) ? "R3" : (pk == 1) ? "R4" : (pk == 2) ? "R5" : "R7";
      end else m_tag <= "R9";
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic set_level(int l);
    lo = (l >= 1); mi = (l >= 2); hi = (l >= 3);
  endtask

  task automatic run_windows(int n);
    int t0;
    t0 = m_ticks;
    while (m_ticks < t0 + n) @(negedge clk);
  endtask

  task automatic pulse_strobe();
    strobe = 1; @(negedge clk); strobe = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_run();
  end

  initial begin
    int seed;
    seed = $urandom(32'd20240611);
    repeat (3) @(negedge clk);
    chk("R1 count in reset", count, 1);
    chk("R1 at_max in reset", at_max, 0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk("R1 count after release", count, 1);

    set_level(0);
    run_windows(1);
    chk("R3 quiet window", count, 2);
    repeat (10) @(negedge clk);
    set_level(1); @(negedge clk); set_level(0);
    run_windows(1);
    chk("R11 one-cycle low excursion holds", count, 2);
    run_windows(1);
    chk("R11 peak cleared next window", count, 3);
    run_windows(4);
    chk("R10 count 7", count, 7);
    chk("R10 at_max at 7", at_max, 1);
    run_windows(2);
    chk("R2 saturate at 7", count, 7);

    set_level(2);
    repeat (TICK / 2) @(negedge clk);
    chk("R9 no change mid-window", count, 7);
    run_windows(1);
    chk("R5 mid window", count, 6);
    chk("R10 at_max below 7", at_max, 0);
    set_level(1);
    run_windows(1);
    chk("R4 low window holds", count, 6);

    set_level(0);
    repeat (3) @(negedge clk);
    set_level(3); @(negedge clk); set_level(0);
    repeat (3) @(negedge clk);
    chk("R6 no force before strobe", count, 6);
    pulse_strobe();
    chk("R6 forced on strobe", count, 1);

    run_windows(3);
    chk("R3 rising after force", count, 3);
    bexit = 1; @(negedge clk); bexit = 0;
    chk("R8 burst exit", count, 1);
    run_windows(3);
    chk("R3 rising to 4", count, 4);
    set_level(3);
    run_windows(1);
    chk("R7 top window without strobe", count, 1);
    set_level(2);
    run_windows(1);
    chk("R2 floor at 1", count, 1);
    set_level(0);
    run_windows(1);
    chk("R3 up from floor", count, 2);

    for (int w = 0; w < 200; w++) begin
      int base;
      base = $urandom % 6;
      base = (base > 3) ? 0 : base;
      for (int c = 0; c < TICK; c++) begin
        int lv;
        lv = base;
        if (($urandom % 64) == 0) lv = $urandom % 4;
        set_level(lv);
        strobe = (($urandom % 8) == 0);
        bexit  = (($urandom % 500) == 0);
        @(negedge clk);
        chk({m_tag, " random count"}, count, m_count);
        chk("R10 random at_max", at_max, (m_count == 7) ? 1 : 0);
      end
    end
    strobe = 0; bexit = 0;
    finish_run();
  end
endmodule